// File: doc/BRIEF.md
# Refill-on-Miss Instruction Fetch Buffer

This block keeps a 16-byte window of the instruction stream between a slow main memory and the instruction decoder. The decoder asks for one halfword at a time. If the requested bytes are already in the window, the halfword comes back one cycle later. If they are not, the block reloads the entire window in one burst. The burst starts at the requested address, and the decoder stalls until the burst is complete and the halfword has been delivered.

When a request marks the first halfword of an instruction, the block reads the instruction length from the opcode byte and requires every byte of that instruction to lie inside the window. An instruction that is absent, or that runs past the end of the window, causes a reload. A taken branch always causes a reload from the target, even when the target is already buffered, so that code altered in memory since the last load is picked up. The block never fetches ahead while the decoder is consuming buffered bytes. Memory latency belongs to the memory side, and the buffer waits for it through its handshake.

Top module: `fetch_window_buf`

## Requirements
- R1: After reset the window is empty. `stall_o`, `hw_valid_o` and `mem_rd_o` are low, and the first request always starts a reload burst.
- R2: A request whose needed bytes all lie in the window returns `hw_valid_o` high in the next cycle. `hw_o` then holds the byte at the request address in bits 15:8 and the next byte in bits 7:0. No memory read is started.
- R3: For a request with `req_start_i` high, the instruction length comes from bits 7:6 of the byte at the request address: 00 gives 2 bytes, 01 and 10 give 4 bytes, 11 gives 6 bytes. The request is a hit only if the address plus that length does not pass the end of the window.
- R4: On a miss, `mem_rd_o` rises with `mem_addr_o` equal to the request address (halfword aligned, bit 0 zero). Both hold until `mem_ready_i`. The block then stores 4 words of 32 bits, one per `mem_wvalid_i`, and the first byte sits in bits 31:24. After the burst, the window covers the 16 bytes that start at that address.
- R5: `stall_o` is high from the cycle after a miss or branch until the pending halfword is delivered. Requests made while `stall_o` is high are ignored.
- R6: A pulse on `flush_i` while not stalled always reloads from `flush_addr_i`, even if that address is buffered. After the reload, hits return the memory contents as they were at reload time. A flush produces no `hw_valid_o`.
- R7: When `flush_i` and `req_i` are high in the same cycle, the request is dropped and `hw_valid_o` stays low in the next cycle.
- R8: The block reads memory only after a miss or a flush. Hits never start a burst, and buffered bytes are not updated when memory changes.
- R9: A flush during a burst lets that burst finish. A new burst from the flush target then follows, and the request that caused the first burst is dropped without a `hw_valid_o`.
- R10: `hw_valid_o` stays low until the last word of a burst has been stored.
- R11: A request with `req_start_i` low needs only its own two bytes to be in the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Decoder halfword request |
| req_start_i | input | 1 | Request is the first halfword of an instruction |
| req_addr_i | input | 24 | Byte address of the requested halfword (bit 0 zero) |
| flush_i | input | 1 | Taken branch, reload from target |
| flush_addr_i | input | 24 | Branch target byte address (bit 0 zero) |
| hw_o | output | 16 | Returned halfword, lower address in bits 15:8 |
| hw_valid_o | output | 1 | `hw_o` valid for one cycle |
| stall_o | output | 1 | Decoder must wait |
| mem_rd_o | output | 1 | Burst read request to memory |
| mem_addr_o | output | 24 | Burst start byte address |
| mem_ready_i | input | 1 | Memory accepted the burst request |
| mem_word_i | input | 32 | Burst data word, lower address in bits 31:24 |
| mem_wvalid_i | input | 1 | `mem_word_i` valid |

## Verification
A hit returns its halfword exactly one cycle after the request edge. The bench samples at the next falling edge and demands a latency of one cycle. A miss cannot return before the memory latency plus four word transfers, so the bench demands a latency longer than that. It also reads the burst count and start address that its memory model records. A flush is due as a stall in the next cycle, so the bench samples `stall_o` and `hw_valid_o` at the falling edge after the flush. It then watches every cycle until the stall ends, so that it catches any stray valid pulse.

// File: rtl/fwb_pkg.sv
package fwb_pkg;

  typedef enum logic [1:0] {
    ST_READY = 2'd0,
    ST_ISSUE = 2'd1,
    ST_FILL  = 2'd2
  } fwb_state_e;

  // Instruction length in bytes from the opcode byte.
  function automatic logic [2:0] insn_bytes(input logic [7:0] opc);
    case (opc[7:6])
      2'b00:   insn_bytes = 3'd2;
      2'b11:   insn_bytes = 3'd6;
      default: insn_bytes = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/fwb_store.sv
module fwb_store #(
  parameter int BUF_BYTES  = 16,
  parameter int WORD_BYTES = 4,
  parameter int ADDR_W     = 24,
  localparam int WORDS     = BUF_BYTES / WORD_BYTES,
  localparam int WORD_BITS = WORD_BYTES * 8,
  localparam int BUF_BITS  = BUF_BYTES * 8,
  localparam int IDX_W     = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [IDX_W-1:0]     wr_idx,
  input  logic [WORD_BITS-1:0] wr_word,
  input  logic                 inval,
  input  logic                 commit,
  input  logic [ADDR_W-1:0]    commit_base,
  output logic [BUF_BITS-1:0]  win_o,
  output logic [ADDR_W-1:0]    base_o,
  output logic                 valid_o
);

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic [WORD_BITS-1:0] word_q;
    logic                 word_en;

    assign word_en = wr_en && (wr_idx == IDX_W'(w));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q <= '0;
      end else if (word_en) begin
        word_q <= wr_word;
      end
    end

    assign win_o[BUF_BITS-1-w*WORD_BITS -: WORD_BITS] = word_q;
  end

  logic              valid_q;
  logic [ADDR_W-1:0] base_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      base_q  <= '0;
    end else if (inval) begin
      valid_q <= 1'b0;
    end else if (commit) begin
      valid_q <= 1'b1;
      base_q  <= commit_base;
    end
  end

  assign valid_o = valid_q;
  assign base_o  = base_q;

endmodule

// File: rtl/fwb_lookup.sv
module fwb_lookup
  import fwb_pkg::*;
#(
  parameter int BUF_BYTES = 16,
  parameter int ADDR_W    = 24,
  localparam int BUF_BITS = BUF_BYTES * 8,
  localparam int OFF_W    = $clog2(BUF_BYTES),
  localparam int HW_CNT   = BUF_BYTES / 2,
  localparam int HW_IDX_W = OFF_W - 1
) (
  input  logic [BUF_BITS-1:0] win_i,
  input  logic [ADDR_W-1:0]   base_i,
  input  logic                valid_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                start_i,
  output logic                hit_o,
  output logic [15:0]         hw_o
);

  logic [ADDR_W-1:0]   off;
  logic                in_win;
  logic [HW_IDX_W-1:0] hw_idx;
  logic [15:0]         hw_arr [HW_CNT];
  logic [2:0]          need;
  logic [OFF_W:0]      end_pos;

  for (genvar h = 0; h < HW_CNT; h++) begin : g_hw
    assign hw_arr[h] = win_i[BUF_BITS-1-h*16 -: 16];
  end

  always_comb begin
    off     = addr_i - base_i;
    in_win  = valid_i && (off[ADDR_W-1:OFF_W] == '0);
    hw_idx  = off[OFF_W-1:1];
    hw_o    = hw_arr[hw_idx];
    need    = start_i ? insn_bytes(hw_o[15:8]) : 3'd2;
    end_pos = {1'b0, off[OFF_W-1:0]} + (OFF_W+1)'(need);
    hit_o   = in_win && (end_pos <= (OFF_W+1)'(BUF_BYTES));
  end

endmodule

// File: rtl/fwb_ctrl.sv
module fwb_ctrl
  import fwb_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int WORDS     = 4,
  localparam int IDX_W    = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic              req_start_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              flush_i,
  input  logic [ADDR_W-1:0] flush_addr_i,
  input  logic              mem_ready_i,
  input  logic              mem_wvalid_i,
  input  logic              lk_hit_i,
  input  logic [15:0]       lk_hw_i,
  output logic [ADDR_W-1:0] lk_addr_o,
  output logic              lk_start_o,
  output logic [15:0]       hw_o,
  output logic              hw_valid_o,
  output logic              stall_o,
  output logic              mem_rd_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              st_wr_en_o,
  output logic [IDX_W-1:0]  st_wr_idx_o,
  output logic              st_inval_o,
  output logic              st_commit_o,
  output logic [ADDR_W-1:0] st_base_o
);

  fwb_state_e        state_q, state_d;
  logic [IDX_W-1:0]  cnt_q, cnt_d;
  logic [ADDR_W-1:0] fill_q, fill_d;
  logic              serve_q, serve_d;
  logic [ADDR_W-1:0] saddr_q, saddr_d;
  logic              sstart_q, sstart_d;
  logic              redo_q, redo_d;
  logic [ADDR_W-1:0] raddr_q, raddr_d;
  logic [15:0]       hw_q, hw_d;
  logic              vld_q, vld_d;
  logic              eff_req;
  logic              last_word;

  assign eff_req    = serve_q | req_i;
  assign lk_addr_o  = serve_q ? saddr_q : req_addr_i;
  assign lk_start_o = serve_q ? sstart_q : req_start_i;
  assign last_word  = (cnt_q == IDX_W'(WORDS-1));

  always_comb begin
    state_d     = state_q;
    cnt_d       = cnt_q;
    fill_d      = fill_q;
    serve_d     = serve_q;
    saddr_d     = saddr_q;
    sstart_d    = sstart_q;
    redo_d      = redo_q;
    raddr_d     = raddr_q;
    hw_d        = hw_q;
    vld_d       = 1'b0;
    st_wr_en_o  = 1'b0;
    st_inval_o  = 1'b0;
    st_commit_o = 1'b0;

    case (state_q)
      ST_READY: begin
        if (flush_i) begin
          state_d    = ST_ISSUE;
          fill_d     = flush_addr_i;
          serve_d    = 1'b0;
          st_inval_o = 1'b1;
        end else if (eff_req) begin
          if (lk_hit_i) begin
            hw_d    = lk_hw_i;
            vld_d   = 1'b1;
            serve_d = 1'b0;
          end else begin
            state_d    = ST_ISSUE;
            fill_d     = lk_addr_o;
            serve_d    = 1'b1;
            saddr_d    = lk_addr_o;
            sstart_d   = lk_start_o;
            st_inval_o = 1'b1;
          end
        end
      end

      ST_ISSUE: begin
        if (mem_ready_i) begin
          state_d = ST_FILL;
          cnt_d   = '0;
        end
        if (flush_i) begin
          serve_d = 1'b0;
          if (mem_ready_i) begin
            redo_d  = 1'b1;
            raddr_d = flush_addr_i;
          end else begin
            fill_d  = flush_addr_i;
          end
        end
      end

      ST_FILL: begin
        if (flush_i) begin
          serve_d = 1'b0;
          redo_d  = 1'b1;
          raddr_d = flush_addr_i;
        end
        if (mem_wvalid_i) begin
          st_wr_en_o = 1'b1;
          cnt_d      = cnt_q + 1'b1;
          if (last_word) begin
            if (redo_q || flush_i) begin
              state_d = ST_ISSUE;
              fill_d  = flush_i ? flush_addr_i : raddr_q;
              redo_d  = 1'b0;
            end else begin
              state_d     = ST_READY;
              st_commit_o = 1'b1;
            end
          end
        end
      end

      default: state_d = ST_READY;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_READY;
      cnt_q    <= '0;
      fill_q   <= '0;
      serve_q  <= 1'b0;
      saddr_q  <= '0;
      sstart_q <= 1'b0;
      redo_q   <= 1'b0;
      raddr_q  <= '0;
      hw_q     <= '0;
      vld_q    <= 1'b0;
    end else begin
      state_q  <= state_d;
      cnt_q    <= cnt_d;
      fill_q   <= fill_d;
      serve_q  <= serve_d;
      saddr_q  <= saddr_d;
      sstart_q <= sstart_d;
      redo_q   <= redo_d;
      raddr_q  <= raddr_d;
      hw_q     <= hw_d;
      vld_q    <= vld_d;
    end
  end

  assign hw_o        = hw_q;
  assign hw_valid_o  = vld_q;
  assign stall_o     = (state_q != ST_READY) || serve_q;
  assign mem_rd_o    = (state_q == ST_ISSUE);
  assign mem_addr_o  = fill_q;
  assign st_wr_idx_o = cnt_q;
  assign st_base_o   = fill_q;

endmodule

// File: rtl/fetch_window_buf.sv
module fetch_window_buf #(
  parameter int BUF_BYTES  = 16,
  parameter int WORD_BYTES = 4,
  parameter int ADDR_W     = 24,
  localparam int WORDS     = BUF_BYTES / WORD_BYTES,
  localparam int WORD_BITS = WORD_BYTES * 8,
  localparam int BUF_BITS  = BUF_BYTES * 8,
  localparam int IDX_W     = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_i,
  input  logic                 req_start_i,
  input  logic [ADDR_W-1:0]    req_addr_i,
  input  logic                 flush_i,
  input  logic [ADDR_W-1:0]    flush_addr_i,
  output logic [15:0]          hw_o,
  output logic                 hw_valid_o,
  output logic                 stall_o,
  output logic                 mem_rd_o,
  output logic [ADDR_W-1:0]    mem_addr_o,
  input  logic                 mem_ready_i,
  input  logic [WORD_BITS-1:0] mem_word_i,
  input  logic                 mem_wvalid_i
);

  logic [BUF_BITS-1:0] win;
  logic [ADDR_W-1:0]   base;
  logic                win_valid;
  logic [ADDR_W-1:0]   lk_addr;
  logic                lk_start;
  logic                lk_hit;
  logic [15:0]         lk_hw;
  logic                st_wr_en;
  logic [IDX_W-1:0]    st_wr_idx;
  logic                st_inval;
  logic                st_commit;
  logic [ADDR_W-1:0]   st_base;

  fwb_store #(
    .BUF_BYTES  (BUF_BYTES),
    .WORD_BYTES (WORD_BYTES),
    .ADDR_W     (ADDR_W)
  ) u_store (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (st_wr_en),
    .wr_idx      (st_wr_idx),
    .wr_word     (mem_word_i),
    .inval       (st_inval),
    .commit      (st_commit),
    .commit_base (st_base),
    .win_o       (win),
    .base_o      (base),
    .valid_o     (win_valid)
  );

  fwb_lookup #(
    .BUF_BYTES (BUF_BYTES),
    .ADDR_W    (ADDR_W)
  ) u_lookup (
    .win_i   (win),
    .base_i  (base),
    .valid_i (win_valid),
    .addr_i  (lk_addr),
    .start_i (lk_start),
    .hit_o   (lk_hit),
    .hw_o    (lk_hw)
  );

  fwb_ctrl #(
    .ADDR_W (ADDR_W),
    .WORDS  (WORDS)
  ) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_i        (req_i),
    .req_start_i  (req_start_i),
    .req_addr_i   (req_addr_i),
    .flush_i      (flush_i),
    .flush_addr_i (flush_addr_i),
    .mem_ready_i  (mem_ready_i),
    .mem_wvalid_i (mem_wvalid_i),
    .lk_hit_i     (lk_hit),
    .lk_hw_i      (lk_hw),
    .lk_addr_o    (lk_addr),
    .lk_start_o   (lk_start),
    .hw_o         (hw_o),
    .hw_valid_o   (hw_valid_o),
    .stall_o      (stall_o),
    .mem_rd_o     (mem_rd_o),
    .mem_addr_o   (mem_addr_o),
    .st_wr_en_o   (st_wr_en),
    .st_wr_idx_o  (st_wr_idx),
    .st_inval_o   (st_inval),
    .st_commit_o  (st_commit),
    .st_base_o    (st_base)
  );

endmodule

// File: rtl/fwb_checker.sv
module fwb_checker #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              flush_i,
  input logic              stall_o,
  input logic              hw_valid_o,
  input logic              mem_rd_o,
  input logic              mem_ready_i,
  input logic [ADDR_W-1:0] mem_addr_o
);

  AST_RD_ONLY_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_o |-> stall_o); // R8

  AST_VALID_NOT_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    hw_valid_o |-> !stall_o); // R5

  AST_NO_VALID_DURING_READ: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_o |-> !hw_valid_o); // R10

  AST_FLUSH_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_i && !stall_o) |=> !hw_valid_o); // R7

  AST_FLUSH_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_i && !stall_o) |=> (stall_o && mem_rd_o)); // R6

  AST_RD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_o && !mem_ready_i) |=> mem_rd_o); // R4

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_o && !mem_ready_i && !flush_i) |=> $stable(mem_addr_o)); // R4

endmodule

bind fetch_window_buf fwb_checker #(.ADDR_W(ADDR_W)) u_fwb_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .flush_i     (flush_i),
  .stall_o     (stall_o),
  .hw_valid_o  (hw_valid_o),
  .mem_rd_o    (mem_rd_o),
  .mem_ready_i (mem_ready_i),
  .mem_addr_o  (mem_addr_o)
);

// File: tb/fetch_window_buf_test.sv
`timescale 1ns/1ps
module fetch_window_buf_test;

  localparam int LAT = 20;

  logic        clk;
  logic        rst_n;
  logic        req_i;
  logic        req_start_i;
  logic [23:0] req_addr_i;
  logic        flush_i;
  logic [23:0] flush_addr_i;
  logic [15:0] hw_o;
  logic        hw_valid_o;
  logic        stall_o;
  logic        mem_rd_o;
  logic [23:0] mem_addr_o;
  logic        mem_ready_i;
  logic [31:0] mem_word_i;
  logic        mem_wvalid_i;

  logic [7:0]  mem [256];
  int          bursts;
  logic [23:0] last_burst;
  int          n_chk;
  int          n_fail;

  fetch_window_buf uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_i        (req_i),
    .req_start_i  (req_start_i),
    .req_addr_i   (req_addr_i),
    .flush_i      (flush_i),
    .flush_addr_i (flush_addr_i),
    .hw_o         (hw_o),
    .hw_valid_o   (hw_valid_o),
    .stall_o      (stall_o),
    .mem_rd_o     (mem_rd_o),
    .mem_addr_o   (mem_addr_o),
    .mem_ready_i  (mem_ready_i),
    .mem_word_i   (mem_word_i),
    .mem_wvalid_i (mem_wvalid_i)
  );

  initial begin
    clk = 1'b0;
    forever #2.5 clk = ~clk;
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_hw(input logic [23:0] a);
    return {mem[a[7:0]], mem[a[7:0] + 8'd1]};
  endfunction

  // Memory model: accepts a burst, waits LAT cycles, returns 4 words.
  initial begin
    mem_ready_i  = 1'b0;
    mem_wvalid_i = 1'b0;
    mem_word_i   = '0;
    bursts       = 0;
    last_burst   = '0;
    forever begin
      @(negedge clk);
      if (rst_n && mem_rd_o) begin
        logic [23:0] ba;
        ba = mem_addr_o;
        mem_ready_i = 1'b1;
        @(negedge clk);
        mem_ready_i = 1'b0;
        bursts++;
        last_burst = ba;
        repeat (LAT) @(negedge clk);
        for (int k = 0; k < 4; k++) begin
          logic [7:0] b;
          b = ba[7:0] + 8'(4*k);
          mem_word_i   = {mem[b], mem[b+8'd1], mem[b+8'd2], mem[b+8'd3]};
          mem_wvalid_i = 1'b1;
          @(negedge clk);
        end
        mem_wvalid_i = 1'b0;
      end
    end
  end

  task automatic do_fetch(input logic [23:0] a, input bit st,
                          output logic [15:0] got, output int cyc);
    @(negedge clk);
    req_i       = 1'b1;
    req_start_i = st;
    req_addr_i  = a;
    @(negedge clk);
    req_i = 1'b0;
    cyc   = 1;
    while (!hw_valid_o && cyc < 2000) begin
      @(negedge clk);
      cyc++;
    end
    got = hw_o;
  endtask

  task automatic do_flush(input logic [23:0] a);
    @(negedge clk);
    flush_i      = 1'b1;
    flush_addr_i = a;
    @(negedge clk);
    flush_i = 1'b0;
  endtask

  task automatic expect_hit(input logic [23:0] a, input bit st, input string tag);
    logic [15:0] got;
    int cyc, b0;
    b0 = bursts;
    do_fetch(a, st, got, cyc);
    check(cyc == 1, tag, "hit latency", cyc, 1);
    check(got == exp_hw(a), tag, "hit data", got, exp_hw(a));
    check(bursts == b0, tag, "no burst on hit", bursts, b0);
  endtask

  task automatic expect_miss(input logic [23:0] a, input bit st, input string tag);
    logic [15:0] got;
    int cyc, b0;
    b0 = bursts;
    do_fetch(a, st, got, cyc);
    check(cyc > LAT + 4, tag, "miss latency", cyc, LAT + 5);
    check(got == exp_hw(a), tag, "miss data", got, exp_hw(a));
    check(bursts == b0 + 1, tag, "one burst", bursts, b0 + 1);
    check(last_burst == a, tag, "burst address", last_burst, a);
  endtask

  // R1 R4 R10: reset state and first request reloads
  task automatic t_reset;
    check(stall_o == 1'b0, "R1", "stall after reset", stall_o, 0);
    check(hw_valid_o == 1'b0, "R1", "valid after reset", hw_valid_o, 0);
    check(mem_rd_o == 1'b0, "R1", "read after reset", mem_rd_o, 0);
    expect_miss(24'h10, 1'b1, "R1");
  endtask

  // R2 R8: sequential hits inside the window
  task automatic t_hits;
    for (int i = 1; i < 8; i++) expect_hit(24'h10 + 24'(2*i), 1'b0, "R2");
  endtask

  // R3 R11: length decode and straddling instructions
  task automatic t_length;
    expect_hit(24'h1A, 1'b1, "R3");   // 6 bytes, ends at window end
    expect_hit(24'h1C, 1'b1, "R3");   // 4 bytes, ends at window end
    expect_hit(24'h1E, 1'b0, "R11");  // continuation, own halfword only
    expect_miss(24'h1E, 1'b1, "R3");  // 4 bytes straddle -> reload
    expect_miss(24'h2A, 1'b1, "R3");  // 6 bytes straddle -> reload
  endtask

  // R6 R8: flush reloads buffered target and picks up modified memory
  task automatic t_branch;
    int b0;
    bit saw_valid;
    expect_hit(24'h2C, 1'b0, "R2");
    mem[8'h2C] = 8'hEE;
    mem[8'h2D] = 8'hDD;
    begin
      logic [15:0] got;
      int cyc;
      do_fetch(24'h2C, 1'b0, got, cyc);
      check(got == 16'h2C2D, "R8", "stale data kept", got, 16'h2C2D);
    end
    b0 = bursts;
    saw_valid = 1'b0;
    do_flush(24'h2C);
    check(stall_o == 1'b1, "R5", "stall after flush", stall_o, 1);
    for (int i = 0; i < 200 && stall_o; i++) begin
      if (hw_valid_o) saw_valid = 1'b1;
      @(negedge clk);
    end
    check(!saw_valid, "R6", "no valid from flush", saw_valid, 0);
    check(bursts == b0 + 1, "R6", "flush burst", bursts, b0 + 1);
    check(last_burst == 24'h2C, "R6", "flush address", last_burst, 24'h2C);
    expect_hit(24'h2C, 1'b0, "R6");
  endtask

  // R7: flush and request together
  task automatic t_prio;
    int b0;
    bit saw_valid;
    b0 = bursts;
    saw_valid = 1'b0;
    @(negedge clk);
    flush_i = 1'b1; flush_addr_i = 24'h40;
    req_i = 1'b1; req_start_i = 1'b0; req_addr_i = 24'h2E;
    @(negedge clk);
    flush_i = 1'b0; req_i = 1'b0;
    check(hw_valid_o == 1'b0, "R7", "request dropped", hw_valid_o, 0);
    check(stall_o == 1'b1, "R7", "flush taken", stall_o, 1);
    for (int i = 0; i < 200 && stall_o; i++) begin
      if (hw_valid_o) saw_valid = 1'b1;
      @(negedge clk);
    end
    check(!saw_valid && !hw_valid_o, "R7", "no late valid", saw_valid, 0);
    check(last_burst == 24'h40 && bursts == b0 + 1, "R7", "burst at target",
          last_burst, 24'h40);
  endtask

  // R5 R10: requests during a stall are ignored
  task automatic t_stall;
    int pulses, b0;
    logic [15:0] got;
    pulses = 0;
    b0 = bursts;
    got = '0;
    @(negedge clk);
    req_i = 1'b1; req_start_i = 1'b1; req_addr_i = 24'h80;
    @(negedge clk);
    req_addr_i = 24'h90;
    for (int i = 0; i < 10; i++) begin
      check(hw_valid_o == 1'b0, "R10", "valid during fill", hw_valid_o, 0);
      @(negedge clk);
    end
    req_i = 1'b0;
    for (int i = 0; i < 200; i++) begin
      if (hw_valid_o) begin
        pulses++;
        got = hw_o;
      end
      @(negedge clk);
    end
    check(pulses == 1, "R5", "single delivery", pulses, 1);
    check(got == exp_hw(24'h80), "R5", "delivered data", got, exp_hw(24'h80));
    check(bursts == b0 + 1, "R5", "single burst", bursts, b0 + 1);
  endtask

  // R9: flush during a burst
  task automatic t_redo;
    int b0;
    bit saw_valid;
    b0 = bursts;
    saw_valid = 1'b0;
    @(negedge clk);
    req_i = 1'b1; req_start_i = 1'b1; req_addr_i = 24'hA0;
    @(negedge clk);
    req_i = 1'b0;
    repeat (5) @(negedge clk);
    flush_i = 1'b1; flush_addr_i = 24'hC0;
    @(negedge clk);
    flush_i = 1'b0;
    for (int i = 0; i < 400 && stall_o; i++) begin
      if (hw_valid_o) saw_valid = 1'b1;
      @(negedge clk);
    end
    check(!saw_valid, "R9", "pending request dropped", saw_valid, 0);
    check(bursts == b0 + 2, "R9", "second burst", bursts, b0 + 2);
    check(last_burst == 24'hC0, "R9", "second burst address", last_burst, 24'hC0);
    expect_hit(24'hC2, 1'b0, "R9");
    expect_miss(24'hA0, 1'b0, "R9");
  endtask

  initial begin
    n_chk = 0;
    n_fail = 0;
    for (int i = 0; i < 256; i++) mem[i] = 8'(i);
    mem[8'h1A] = 8'hC3;
    mem[8'h1C] = 8'h9A;
    mem[8'h1E] = 8'h47;
    mem[8'h2A] = 8'hC3;
    rst_n = 1'b0;
    req_i = 1'b0; req_start_i = 1'b0; req_addr_i = '0;
    flush_i = 1'b0; flush_addr_i = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_hits();
    t_length();
    t_branch();
    t_prio();
    t_stall();
    t_redo();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule